// File: doc/BRIEF.md
# Instruction fetch address translator

This block maps the address of an instruction fetch to a physical address, or reports why it cannot. Each fetch request carries the fetch PC, a flag that asks for the address to be used untranslated, the current privilege mode and the address-space number. The block offers a lookup key (virtual page number and address-space number) to an external translation buffer. It takes back the buffer's answer in the same cycle: a hit flag, a physical page number and a per-mode execute mask. The response is registered and appears one cycle after the request.

The block picks one of several paths. Privileged code is marked by PC bit 0 and bypasses translation. Physical mode passes the address through. A fixed kernel-only window of the virtual space maps directly onto physical memory. Every other fetch goes through the translation buffer. A physical address that leaves the implemented range raises a machine check. Addresses in the uncacheable half of the physical space are flagged and have their middle bits cleared. A window inside that half, reserved for internal registers, is reported as unimplemented.

Top module: `ift_xlate`

## Requirements
- R1: When fetch_pc[0] is 1, the response has fault code 0, rsp_uncached 0 and rsp_pa equal to fetch_pc[43:0] with bits 1:0 cleared. This holds whatever the other inputs are, including fetch_pc[43] set.
- R2: When fetch_pc[0] is 0 and phys_mode is 1, the candidate physical address is fetch_pc unchanged. It is then subject to R8 and R9 only.
- R3: When neither R1 nor R2 applies and fetch_pc[63:47] is neither all zeros nor all ones, the fault code is 1 (access violation).
- R4: When fetch_pc[47:41] equals 7'h7E and cur_mode is not 0 (kernel = 0, user = 3), the fault code is 1. In kernel mode the candidate is fetch_pc[43:0] with bits 43:40 set to 4'hF if fetch_pc[40] is 1 and cleared otherwise.
- R5: tlb_vpn always equals fetch_pc[63:13] and tlb_asn always equals asn. On a translated fetch with tlb_hit 0, the fault code is 2 (page miss).
- R6: On a translation hit, the candidate is tlb_ppn shifted left by 13 plus fetch_pc[12:0] with bits 1:0 cleared.
- R7: On a translation hit where bit cur_mode of tlb_exec_mask is 0, the fault code is 1. This check ranks above R8.
- R8: When a candidate from R2, R4 or R6 has any bit above bit 43 set, the fault code is 3 (machine check).
- R9: When the candidate's bit 43 is 1 and bits 42:41 equal 2'b10, the fault code is 4 (unimplemented). When bit 43 is 1 and bits 42:41 take any other value, rsp_uncached is 1 and rsp_pa has bits 42:35 cleared.
- R10: rsp_valid is 1 exactly in the cycle after a cycle with req_valid 1, and it is 0 after reset. Whenever the fault code is nonzero, rsp_pa and rsp_uncached are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fetch request present this cycle |
| fetch_pc | input | 64 | Fetch virtual address; bit 0 marks privileged code |
| phys_mode | input | 1 | Use the address untranslated |
| cur_mode | input | 2 | Privilege mode, kernel 0, user 3 |
| asn | input | 8 | Address-space number |
| tlb_vpn | output | 51 | Lookup key: virtual page number |
| tlb_asn | output | 8 | Lookup key: address-space number |
| tlb_hit | input | 1 | Translation buffer hit |
| tlb_ppn | input | 32 | Physical page number on hit |
| tlb_exec_mask | input | 4 | Execute permission, one bit per mode |
| rsp_valid | output | 1 | Response present |
| rsp_pa | output | 44 | Physical address |
| rsp_uncached | output | 1 | Access is uncacheable |
| rsp_fault | output | 3 | 0 none, 1 access violation, 2 miss, 3 machine check, 4 unimplemented |

## Verification
The bench goes after the precedence edges. A privileged PC with bit 43 set must come back clean, or the design is wrongly applying the cacheability step to the bypass. A non-canonical address in physical mode must give a machine check rather than a violation, or the path order is broken. A global entry must hit under a foreign address-space number. A page number that pushes the address past bit 43 must raise a machine check, or the range test is being done on the truncated address. In the kernel window, bit 40 must decide whether the upper nibble is filled. Uncached addresses outside the register window must have bits 42:35 stripped. A design that strips the wrong field, or lets a fault leak a stale address, disagrees with the per-cycle reference model.

// File: rtl/ift_pkg.sv
package ift_pkg;
  localparam int VA_W      = 64;
  localparam int VA_IMPL   = 48;
  localparam int PA_W      = 44;
  localparam int PG_BITS   = 13;
  localparam int VPN_W     = VA_W - PG_BITS;
  localparam int UC_BIT    = 43;
  localparam int STRIP_HI  = 42;
  localparam int STRIP_LO  = 35;
  localparam int SP_EXT    = 40;
  localparam int SP_TAG_HI = 47;
  localparam int SP_TAG_LO = 41;
  localparam int CANON_W   = VA_W - VA_IMPL + 1;
  localparam logic [SP_TAG_HI-SP_TAG_LO:0] SP_TAG = 7'h7E;
  localparam int WIN_HI    = 42;
  localparam int WIN_LO    = 41;
  localparam logic [1:0] WIN_SEL = 2'b10;

  typedef logic [VA_W-1:0] va_t;
  typedef logic [PA_W-1:0] pa_t;

  typedef enum logic [2:0] {
    FLT_NONE  = 3'd0,
    FLT_ACV   = 3'd1,
    FLT_MISS  = 3'd2,
    FLT_MCHK  = 3'd3,
    FLT_UNIMP = 3'd4
  } fault_e;

  typedef enum logic [2:0] {
    PATH_BYPASS,
    PATH_PHYS,
    PATH_BADVA,
    PATH_SPDENY,
    PATH_SPAGE,
    PATH_TLB
  } path_e;

  // Upper bits must be a pure sign extension of the implemented width.
  function automatic logic va_canonical(input logic [CANON_W-1:0] hi);
    return (&hi) | (~|hi);
  endfunction

  // Kernel window: bit 40 decides whether the top nibble is filled.
  function automatic pa_t superpage_pa(input pa_t low);
    pa_t p;
    p = low;
    if (p[SP_EXT]) p[PA_W-1:SP_EXT] = '1;
    else           p[PA_W-1:SP_EXT] = '0;
    return p;
  endfunction

  function automatic va_t hit_pa(input va_t ppn_ext, input logic [PG_BITS-1:2] off_hi);
    va_t off;
    off = '0;
    off[PG_BITS-1:2] = off_hi;
    return (ppn_ext << PG_BITS) + off;
  endfunction

  function automatic pa_t bypass_pa(input logic [PA_W-1:2] hi);
    return {hi, 2'b00};
  endfunction

  function automatic logic impl_ok(input logic [VA_W-1:PA_W] hi);
    return ~|hi;
  endfunction

  function automatic logic in_reg_window(input logic [WIN_HI:WIN_LO] sel);
    return sel == WIN_SEL;
  endfunction

  function automatic pa_t strip_uncached(input pa_t p);
    pa_t q;
    q = p;
    q[STRIP_HI:STRIP_LO] = '0;
    return q;
  endfunction
endpackage

// File: rtl/ift_classify.sv
module ift_classify
  import ift_pkg::*;
#(
  parameter int MODE_W = 2
) (
  input  logic [VA_W-1:SP_TAG_LO] pc_hi,
  input  logic                    pc_lsb,
  input  logic                    phys_mode,
  input  logic [MODE_W-1:0]       cur_mode,
  output path_e                   path
);
  logic canon;
  logic sp_win;

  assign canon  = va_canonical(pc_hi[VA_W-1:VA_IMPL-1]);
  assign sp_win = pc_hi[SP_TAG_HI:SP_TAG_LO] == SP_TAG;

  always_comb begin
    if (pc_lsb)           path = PATH_BYPASS;
    else if (phys_mode)   path = PATH_PHYS;
    else if (!canon)      path = PATH_BADVA;
    else if (sp_win)      path = (cur_mode != '0) ? PATH_SPDENY : PATH_SPAGE;
    else                  path = PATH_TLB;
  end
endmodule

// File: rtl/ift_pa_form.sv
module ift_pa_form
  import ift_pkg::*;
#(
  parameter int PPN_W  = 32,
  parameter int MODE_W = 2,
  localparam int N_MODES = 1 << MODE_W
) (
  input  path_e              path,
  input  va_t                pc,
  input  logic [MODE_W-1:0]  cur_mode,
  input  logic               tlb_hit,
  input  logic [PPN_W-1:0]   tlb_ppn,
  input  logic [N_MODES-1:0] tlb_exec_mask,
  output va_t                cand,
  output fault_e             pre_fault,
  output logic               post_en,
  output logic               tlb_miss_w,
  output logic               perm_deny_w
);
  logic [N_MODES-1:0] mode_grant;
  logic               perm_ok;

  for (genvar m = 0; m < N_MODES; m++) begin : g_mode
    assign mode_grant[m] = (cur_mode == MODE_W'(m)) & tlb_exec_mask[m];
  end
  assign perm_ok = |mode_grant;

  assign tlb_miss_w  = (path == PATH_TLB) && !tlb_hit;
  assign perm_deny_w = (path == PATH_TLB) && tlb_hit && !perm_ok;

  always_comb begin
    cand      = '0;
    pre_fault = FLT_NONE;
    post_en   = 1'b0;
    case (path)
      PATH_BYPASS: cand = va_t'(bypass_pa(pc[PA_W-1:2]));
      PATH_PHYS: begin
        cand    = pc;
        post_en = 1'b1;
      end
      PATH_BADVA:  pre_fault = FLT_ACV;
      PATH_SPDENY: pre_fault = FLT_ACV;
      PATH_SPAGE: begin
        cand    = va_t'(superpage_pa(pc[PA_W-1:0]));
        post_en = 1'b1;
      end
      PATH_TLB: begin
        cand = hit_pa(va_t'(tlb_ppn), pc[PG_BITS-1:2]);
        if (!tlb_hit)      pre_fault = FLT_MISS;
        else if (!perm_ok) pre_fault = FLT_ACV;
        else               post_en   = 1'b1;
      end
      default: pre_fault = FLT_ACV;
    endcase
  end
endmodule

// File: rtl/ift_phys_check.sv
module ift_phys_check
  import ift_pkg::*;
(
  input  va_t    cand,
  input  fault_e pre_fault,
  input  logic   post_en,
  output pa_t    pa,
  output logic   uncached,
  output fault_e fault,
  output logic   mchk_w,
  output logic   unimp_w
);
  logic range_ok;
  logic uc_hit;

  assign range_ok = impl_ok(cand[VA_W-1:PA_W]);
  assign uc_hit   = post_en && range_ok && cand[UC_BIT];
  assign mchk_w   = post_en && (pre_fault == FLT_NONE) && !range_ok;
  assign unimp_w  = uc_hit && (pre_fault == FLT_NONE) && in_reg_window(cand[WIN_HI:WIN_LO]);

  always_comb begin
    fault    = pre_fault;
    pa       = '0;
    uncached = 1'b0;
    if (pre_fault == FLT_NONE) begin
      if (mchk_w)       fault = FLT_MCHK;
      else if (unimp_w) fault = FLT_UNIMP;
      else if (uc_hit) begin
        pa       = strip_uncached(cand[PA_W-1:0]);
        uncached = 1'b1;
      end else begin
        pa = cand[PA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ift_xlate.sv
module ift_xlate
  import ift_pkg::*;
#(
  parameter int PPN_W  = 32,
  parameter int ASN_W  = 8,
  parameter int MODE_W = 2,
  localparam int N_MODES = 1 << MODE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [63:0]        fetch_pc,
  input  logic               phys_mode,
  input  logic [MODE_W-1:0]  cur_mode,
  input  logic [ASN_W-1:0]   asn,
  output logic [50:0]        tlb_vpn,
  output logic [ASN_W-1:0]   tlb_asn,
  input  logic               tlb_hit,
  input  logic [PPN_W-1:0]   tlb_ppn,
  input  logic [N_MODES-1:0] tlb_exec_mask,
  output logic               rsp_valid,
  output logic [43:0]        rsp_pa,
  output logic               rsp_uncached,
  output logic [2:0]         rsp_fault
);
  path_e  path;
  va_t    cand;
  fault_e pre_fault;
  fault_e fault;
  logic   post_en;
  pa_t    pa_n;
  logic   unc_n;
  logic   tlb_miss_w;
  logic   perm_deny_w;
  logic   mchk_w;
  logic   unimp_w;
  logic   sp_deny_w;

  assign tlb_vpn   = fetch_pc[VA_W-1:PG_BITS];
  assign tlb_asn   = asn;
  assign sp_deny_w = (path == PATH_SPDENY);

  ift_classify #(.MODE_W(MODE_W)) u_cls (
    .pc_hi     (fetch_pc[VA_W-1:SP_TAG_LO]),
    .pc_lsb    (fetch_pc[0]),
    .phys_mode (phys_mode),
    .cur_mode  (cur_mode),
    .path      (path)
  );

  ift_pa_form #(.PPN_W(PPN_W), .MODE_W(MODE_W)) u_form (
    .path          (path),
    .pc            (fetch_pc),
    .cur_mode      (cur_mode),
    .tlb_hit       (tlb_hit),
    .tlb_ppn       (tlb_ppn),
    .tlb_exec_mask (tlb_exec_mask),
    .cand          (cand),
    .pre_fault     (pre_fault),
    .post_en       (post_en),
    .tlb_miss_w    (tlb_miss_w),
    .perm_deny_w   (perm_deny_w)
  );

  ift_phys_check u_chk_pa (
    .cand      (cand),
    .pre_fault (pre_fault),
    .post_en   (post_en),
    .pa        (pa_n),
    .uncached  (unc_n),
    .fault     (fault),
    .mchk_w    (mchk_w),
    .unimp_w   (unimp_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_pa       <= '0;
      rsp_uncached <= 1'b0;
      rsp_fault    <= FLT_NONE;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_pa       <= pa_n;
        rsp_uncached <= unc_n;
        rsp_fault    <= fault;
      end
    end
  end
endmodule

// File: rtl/ift_xlate_chk.sv
module ift_xlate_chk
  import ift_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        pc_lsb,
  input logic        sp_deny_w,
  input logic        tlb_miss_w,
  input logic        perm_deny_w,
  input logic        mchk_w,
  input logic        unimp_w,
  input logic        rsp_valid,
  input logic [43:0] rsp_pa,
  input logic        rsp_uncached,
  input logic [2:0]  rsp_fault
);
  assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);
  assert_fault_zeroes_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 3'd0) |-> (rsp_pa == '0 && !rsp_uncached));
  assert_bypass_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && pc_lsb) |=> (rsp_fault == 3'd0 && !rsp_uncached));
  assert_spage_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && sp_deny_w) |=> rsp_fault == 3'(FLT_ACV));
  assert_miss_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && tlb_miss_w) |=> rsp_fault == 3'(FLT_MISS));
  assert_perm_deny_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && perm_deny_w) |=> rsp_fault == 3'(FLT_ACV));
  assert_mchk_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mchk_w) |=> rsp_fault == 3'(FLT_MCHK));
  assert_unimp_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && unimp_w) |=> rsp_fault == 3'(FLT_UNIMP));
  assert_uc_strip_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_uncached) |-> (rsp_pa[43] && rsp_pa[42:35] == 8'h00));
endmodule

bind ift_xlate ift_xlate_chk u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .pc_lsb       (fetch_pc[0]),
  .sp_deny_w    (sp_deny_w),
  .tlb_miss_w   (tlb_miss_w),
  .perm_deny_w  (perm_deny_w),
  .mchk_w       (mchk_w),
  .unimp_w      (unimp_w),
  .rsp_valid    (rsp_valid),
  .rsp_pa       (rsp_pa),
  .rsp_uncached (rsp_uncached),
  .rsp_fault    (rsp_fault)
);

// File: tb/tb_ift_xlate.sv
`timescale 1ns/1ps
module tb_ift_xlate;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [63:0] fetch_pc = '0;
  logic        phys_mode = 1'b0;
  logic [1:0]  cur_mode = '0;
  logic [7:0]  asn = '0;
  logic [50:0] tlb_vpn;
  logic [7:0]  tlb_asn;
  logic        tlb_hit;
  logic [31:0] tlb_ppn;
  logic [3:0]  tlb_exec_mask;
  logic        rsp_valid;
  logic [43:0] rsp_pa;
  logic        rsp_uncached;
  logic [2:0]  rsp_fault;

  always #2.5 clk = ~clk;

  ift_xlate dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fetch_pc(fetch_pc),
    .phys_mode(phys_mode), .cur_mode(cur_mode), .asn(asn),
    .tlb_vpn(tlb_vpn), .tlb_asn(tlb_asn), .tlb_hit(tlb_hit),
    .tlb_ppn(tlb_ppn), .tlb_exec_mask(tlb_exec_mask),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_uncached(rsp_uncached),
    .rsp_fault(rsp_fault)
  );

  // Translation buffer model: four fixed entries.
  logic [50:0] e_vpn [4];
  logic [7:0]  e_asn [4];
  logic        e_glob[4];
  logic [31:0] e_ppn [4];
  logic [3:0]  e_xm  [4];

  always_comb begin
    tlb_hit = 1'b0;
    tlb_ppn = '0;
    tlb_exec_mask = '0;
    for (int i = 0; i < 4; i++) begin
      if (!tlb_hit && e_vpn[i] == tlb_vpn && (e_glob[i] || e_asn[i] == tlb_asn)) begin
        tlb_hit = 1'b1;
        tlb_ppn = e_ppn[i];
        tlb_exec_mask = e_xm[i];
      end
    end
  end

  typedef struct {
    bit [43:0] pa;
    bit        unc;
    int        flt;
    string     tag;
  } exp_t;

  exp_t expq[$];
  int   n_run = 0;
  int   n_fail = 0;
  bit   run = 0;
  bit   done = 0;

  // Behavioural reference, written from the requirement text.
  function automatic exp_t ref_model(bit [63:0] pc, bit phys, bit [1:0] mode,
                                     bit [7:0] a, string tag);
    exp_t r;
    bit [63:0] p;
    bit [16:0] top;
    int idx;
    r.pa = 0; r.unc = 0; r.flt = 0; r.tag = tag;
    if (pc[0]) begin
      p = pc & ~64'd3;
      r.pa = p[43:0];
      return r;
    end
    if (phys) p = pc;
    else begin
      top = pc[63:47];
      if (!(top == 17'd0 || top == 17'h1FFFF)) begin r.flt = 1; return r; end
      if (((pc >> 41) & 64'h7F) == 64'h7E) begin
        if (mode != 2'd0) begin r.flt = 1; return r; end
        p = pc & ((64'd1 << 44) - 1);
        if (p[40]) p = p | (64'hF << 40);
        else       p = p & ((64'd1 << 40) - 1);
      end else begin
        idx = -1;
        for (int i = 0; i < 4; i++)
          if (idx < 0 && {13'd0, e_vpn[i]} == (pc >> 13) && (e_glob[i] || e_asn[i] == a)) idx = i;
        if (idx < 0) begin r.flt = 2; return r; end
        p = (64'(e_ppn[idx]) * 64'd8192) + ((pc % 64'd8192) & ~64'd3);
        if (!e_xm[idx][mode]) begin r.flt = 1; return r; end
      end
    end
    if ((p >> 44) != 0) begin r.flt = 3; return r; end
    if (p[43]) begin
      if (p[42:41] == 2'b10) begin r.flt = 4; return r; end
      p[42:35] = 8'd0;
      r.unc = 1;
    end
    r.pa = p[43:0];
    return r;
  endfunction

  always @(negedge clk) begin
    if (run) begin
      if (expq.size() > 0) begin
        exp_t e;
        e = expq.pop_front();
        n_run++;
        if (!(rsp_valid === 1'b1 && rsp_fault === 3'(e.flt) && rsp_pa === e.pa &&
              rsp_uncached === e.unc)) begin
          n_fail++;
          $display("FAIL %s: got v=%0b f=%0d pa=%h uc=%0b, expected v=1 f=%0d pa=%h uc=%0b",
                   e.tag, rsp_valid, rsp_fault, rsp_pa, rsp_uncached, e.flt, e.pa, e.unc);
        end
      end else begin
        n_run++;
        if (rsp_valid !== 1'b0) begin
          n_fail++;
          $display("FAIL R10: idle cycle got rsp_valid=%0b, expected 0", rsp_valid);
        end
      end
    end
  end

  task automatic send(bit [63:0] pc, bit phys, bit [1:0] mode, bit [7:0] a, string tag);
    @(negedge clk);
    #1;
    fetch_pc = pc; phys_mode = phys; cur_mode = mode; asn = a; req_valid = 1'b1;
    expq.push_back(ref_model(pc, phys, mode, a, tag));
    #1;
    n_run++;
    if (tlb_vpn !== pc[63:13] || tlb_asn !== a) begin
      n_fail++;
      $display("FAIL R5: lookup key got vpn=%h asn=%h, expected vpn=%h asn=%h",
               tlb_vpn, tlb_asn, pc[63:13], a);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL R10: watchdog got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    bit [63:0] lcg;
    e_vpn[0] = 51'h201; e_asn[0] = 8'd5; e_glob[0] = 0; e_ppn[0] = 32'h0000_1234; e_xm[0] = 4'b1001;
    e_vpn[1] = 51'h300; e_asn[1] = 8'd5; e_glob[1] = 1; e_ppn[1] = 32'h8000_0001; e_xm[1] = 4'b1111;
    e_vpn[2] = 51'h400; e_asn[2] = 8'd5; e_glob[2] = 0; e_ppn[2] = 32'h4000_0010; e_xm[2] = 4'b1001;
    e_vpn[3] = 51'h500; e_asn[3] = 8'd5; e_glob[3] = 0; e_ppn[3] = 32'h6000_0000; e_xm[3] = 4'b1111;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    n_run++;
    if (rsp_valid !== 1'b0 || rsp_fault !== 3'd0) begin
      n_fail++;
      $display("FAIL R10: reset state got v=%0b f=%0d, expected v=0 f=0", rsp_valid, rsp_fault);
    end
    run = 1;

    send(64'hFFFF_F923_4567_89AB, 1'b0, 2'd3, 8'd0, "R1");
    send(64'h0000_0012_3456_7801, 1'b1, 2'd0, 8'd0, "R1");
    send(64'h0000_0123_4567_8AB4, 1'b1, 2'd3, 8'd0, "R2");
    send(64'h0001_0000_0000_0000, 1'b1, 2'd0, 8'd0, "R8");
    send(64'h0000_0A00_0000_1000, 1'b1, 2'd0, 8'd0, "R9");
    send(64'h0000_0C00_1234_5000, 1'b1, 2'd0, 8'd0, "R9");
    idle();
    send(64'h0001_0000_0000_0000, 1'b0, 2'd0, 8'd0, "R3");
    send(64'hFFFE_8000_0000_0000, 1'b0, 2'd0, 8'd0, "R3");
    send(64'hFFFF_FD12_3456_7800, 1'b0, 2'd0, 8'd0, "R4");
    send(64'hFFFF_FC12_3456_7800, 1'b0, 2'd0, 8'd0, "R4");
    send(64'hFFFF_FC12_3456_7800, 1'b0, 2'd3, 8'd0, "R4");
    send(64'h0000_0000_0040_A000, 1'b0, 2'd0, 8'd5, "R5");
    send(64'h0000_0000_0040_21A6, 1'b0, 2'd6 % 4, 8'd6, "R5");
    idle();
    send(64'h0000_0000_0040_21A6, 1'b0, 2'd0, 8'd5, "R6");
    send(64'h0000_0000_0040_3FFE, 1'b0, 2'd3, 8'd5, "R6");
    send(64'h0000_0000_0040_2010, 1'b0, 2'd1, 8'd5, "R7");
    send(64'h0000_0000_0060_0004, 1'b0, 2'd2, 8'd9, "R8");
    send(64'h0000_0000_0080_0008, 1'b0, 2'd0, 8'd5, "R9");
    send(64'h0000_0000_0080_0008, 1'b0, 2'd1, 8'd5, "R7");
    send(64'h0000_0000_00A0_0100, 1'b0, 2'd3, 8'd5, "R9");
    idle();
    idle();

    lcg = 64'h1234_5678_9ABC_DEF1;
    for (int k = 0; k < 60; k++) begin
      bit [63:0] pc;
      string tg;
      lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
      case (lcg[63:61] % 3'd6)
        3'd0: begin pc = lcg | 64'd1; tg = "R1"; end
        3'd1: begin pc = (lcg >> 7) & 64'h1F_FFFF_FFFF_FFFE; tg = "R2"; end
        3'd2: begin pc = 64'h0002_0000_0000_0000 | (lcg & 64'hFFFE); tg = "R3"; end
        3'd3: begin pc = 64'hFFFF_FC00_0000_0000 | (lcg & 64'h1FF_FFFF_FFFE); tg = "R4"; end
        3'd4: begin pc = ({13'd0, e_vpn[lcg[5:4]]} << 13) | (lcg & 64'h1FFE); tg = "R6"; end
        default: begin pc = (lcg & 64'h0000_3FFF_FFFF_E000) | 64'h2000_0000; tg = "R5"; end
      endcase
      if (lcg[63:61] == 3'd1) send(pc, 1'b1, lcg[9:8], lcg[17:10], tg);
      else send(pc, 1'b0, lcg[9:8], (lcg[3]) ? 8'd5 : lcg[17:10], tg);
      if (lcg[20]) idle();
    end
    idle();
    idle();
    @(negedge clk);
    run = 0;
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule